// File: doc/BRIEF.md
# Byte Serializer-Deserializer with Frame Alignment

This block is the digital datapath of an optical-style line interface. All of it runs on one clock at the serial bit rate. On the transmit side it produces a byte-rate strobe, one cycle in every eight. On each strobe it takes in an 8-bit word and shifts that word out on a single serial pin, most significant bit first.

On the receive side a 48-bit window slides over the incoming serial bits. When it holds the framing sequence (three 0xF6 bytes followed by three 0x28 bytes) at any bit offset, and the hunt input is high, the byte counter is realigned. From then on, received bytes come out on whole-byte boundaries with a one-cycle valid strobe. A frame marker flags the last byte of the sequence.

Two loopbacks are available. The serial loop sends received serial bits straight back out of the transmit pin. The parallel loop sends transmit bytes straight to the receive parallel outputs. Both loop selects take effect only at a byte-strobe boundary. With neither set, the transmit and receive paths run independently.

Top module: `byte_serdes_framer`

## Requirements
- R1: `tx_bclk_o` is high for exactly one clock in every 8. After reset release its first high cycle follows the 7th rising edge.
- R2: On each rising edge with `tx_bclk_o` high, `tx_byte_i` is loaded. The next 8 cycles of `tx_ser_o` carry bit 7 down to bit 0 of that byte, each for one clock.
- R3: While `rst_ni` is low, `tx_ser_o`, `tx_bclk_o`, `rx_bclk_o`, `frame_o` and `rx_byte_o` are all 0.
- R4: While `hunt_i` is 1, the sequence F6 F6 F6 28 28 28 at any bit offset of `rx_ser_i` realigns the receiver. The first 0xF6 is output intact, and every later byte is output on the same 8-bit boundary, each marked by a one-cycle `rx_bclk_o`.
- R5: `frame_o` is high together with `rx_bclk_o` for exactly the output byte that completes the sequence (the third 0x28), and is low otherwise.
- R6: While `hunt_i` is 0, the byte boundary is held. A sequence at another bit offset neither realigns the receiver nor raises `frame_o`.
- R7: When the serial loop is active, `tx_ser_o` equals the value `rx_ser_i` had at the previous rising edge, replacing the serialized data.
- R8: When the parallel loop is active, each loaded transmit byte appears on `rx_byte_o` with `rx_bclk_o` high in the cycle after the load, and `frame_o` stays 0.
- R9: `serial_loop_i` and `parallel_loop_i` are sampled only on rising edges with `tx_bclk_o` high. A change mid-byte does not alter the byte being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_byte_i | input | 8 | Transmit byte, sampled on the byte strobe |
| tx_bclk_o | output | 1 | Byte-rate strobe (bit clock divided by 8) |
| tx_ser_o | output | 1 | Transmit serial bit |
| rx_ser_i | input | 1 | Receive serial bit |
| hunt_i | input | 1 | Out-of-frame: high enables realignment |
| serial_loop_i | input | 1 | Route received serial bits to the transmit pin |
| parallel_loop_i | input | 1 | Route transmit bytes to the receive outputs |
| rx_byte_o | output | 8 | Received aligned byte |
| rx_bclk_o | output | 1 | One-cycle strobe marking a new `rx_byte_o` |
| frame_o | output | 1 | High with the byte that completes the framing sequence |

## Verification
The serializer is driven with a table of bytes: all-zero, all-one, single-bit-high at either end, and alternating patterns. These separate a bit-order error from a shift-count error.

The receiver is given the framing sequence twice at different bit offsets after a run of noise bits. Between those two runs, a third run arrives at a shifted offset while hunting is off. This tells true realignment apart from a fixed boundary and from a frame marker that ignores the hold.

Each loopback is switched on in the middle of a byte, using data that differs from the looped-back source. This distinguishes sampling on the byte strobe from immediate switching.

// File: rtl/serdes_pkg.sv
package serdes_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FRM_LEN = 6;  // bytes in the framing sequence
  localparam logic [BYTE_W-1:0] SYNC_HI = 8'hF6;
  localparam logic [BYTE_W-1:0] SYNC_LO = 8'h28;
endpackage

// File: rtl/byte_strobe_gen.sv
module byte_strobe_gen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  localparam int unsigned CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = (cnt_q == LAST);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         bit_o
);
  logic [W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else if (load_i) sreg_q <= data_i;
    else sreg_q <= {sreg_q[W-2:0], 1'b0};
  end

  assign bit_o = sreg_q[W-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer #(
  parameter int unsigned W      = 8,
  parameter int unsigned NBYTES = 6,
  parameter logic [W-1:0] HI    = 8'hF6,
  parameter logic [W-1:0] LO    = 8'h28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         hunt_i,
  output logic [W-1:0] byte_o,
  output logic         vld_o,
  output logic         frame_o,
  output logic         last_bit_o
);
  localparam int unsigned PW = W * NBYTES;
  localparam int unsigned BW = $clog2(W);
  localparam int unsigned FW = $clog2(NBYTES);
  localparam logic [BW-1:0] B_LAST = BW'(W - 1);
  localparam logic [FW-1:0] F_LAST = FW'(NBYTES - 1);

  logic [PW-1:0] win_q, pat;
  logic [BW-1:0] bcnt_q;
  logic [FW-1:0] fcnt_q;
  logic          match, realign, hit, emit;

  // low-order bytes arrive last: they hold the LO half
  for (genvar g = 0; g < NBYTES; g++) begin : g_pat
    assign pat[(g+1)*W-1 -: W] = (g < NBYTES/2) ? LO : HI;
  end

  assign match   = (win_q == pat);
  assign realign = match && hunt_i;
  assign hit     = match && (hunt_i || bcnt_q == B_LAST);
  assign emit    = realign || (bcnt_q == B_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      bcnt_q  <= '0;
      fcnt_q  <= '0;
      byte_o  <= '0;
      vld_o   <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      win_q   <= {win_q[PW-2:0], bit_i};
      bcnt_q  <= emit ? '0 : bcnt_q + 1'b1;
      vld_o   <= emit;
      frame_o <= 1'b0;
      if (emit) begin
        byte_o <= win_q[PW-1 -: W];
        if (hit) fcnt_q <= FW'(1);
        else if (fcnt_q == F_LAST) begin
          fcnt_q  <= '0;
          frame_o <= 1'b1;
        end else if (fcnt_q != '0) fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  assign last_bit_o = win_q[0];
endmodule

// File: rtl/byte_serdes_framer.sv
module byte_serdes_framer
  import serdes_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tx_byte_i,
  output logic         tx_bclk_o,
  output logic         tx_ser_o,
  input  logic         rx_ser_i,
  input  logic         hunt_i,
  input  logic         serial_loop_i,
  input  logic         parallel_loop_i,
  output logic [W-1:0] rx_byte_o,
  output logic         rx_bclk_o,
  output logic         frame_o
);
  logic         ser_bit, rx_last;
  logic         fac_q, eqp_q;
  logic [W-1:0] fr_byte, eq_byte_q;
  logic         fr_vld, fr_frame, eq_vld_q;

  byte_strobe_gen #(.DIV(W)) i_strobe (
    .clk_i, .rst_ni, .strobe_o(tx_bclk_o)
  );

  tx_shifter #(.W(W)) i_tx (
    .clk_i, .rst_ni, .load_i(tx_bclk_o), .data_i(tx_byte_i), .bit_o(ser_bit)
  );

  rx_framer #(.W(W), .NBYTES(FRM_LEN), .HI(SYNC_HI), .LO(SYNC_LO)) i_rx (
    .clk_i, .rst_ni, .bit_i(rx_ser_i), .hunt_i,
    .byte_o(fr_byte), .vld_o(fr_vld), .frame_o(fr_frame), .last_bit_o(rx_last)
  );

  // loop selects change only on byte boundaries; byte-side loop path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fac_q     <= 1'b0;
      eqp_q     <= 1'b0;
      eq_byte_q <= '0;
      eq_vld_q  <= 1'b0;
    end else begin
      eq_vld_q <= tx_bclk_o;
      if (tx_bclk_o) begin
        fac_q     <= serial_loop_i;
        eqp_q     <= parallel_loop_i;
        eq_byte_q <= tx_byte_i;
      end
    end
  end

  assign tx_ser_o  = fac_q ? rx_last : ser_bit;
  assign rx_byte_o = eqp_q ? eq_byte_q : fr_byte;
  assign rx_bclk_o = eqp_q ? eq_vld_q : fr_vld;
  assign frame_o   = eqp_q ? 1'b0 : fr_frame;
endmodule

// File: rtl/byte_serdes_framer_chk.sv
module byte_serdes_framer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] tx_byte_i,
  input logic         tx_bclk_o,
  input logic         tx_ser_o,
  input logic         rx_ser_i,
  input logic [W-1:0] rx_byte_o,
  input logic         rx_bclk_o,
  input logic         frame_o,
  input logic         fac_q,
  input logic         eqp_q
);
  a_r1_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_bclk_o |=> !tx_bclk_o);

  a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_bclk_o) && !fac_q) |-> (tx_ser_o == $past(tx_byte_i[W-1])));

  a_r5_frame_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (rx_bclk_o && rx_byte_o == 8'h28));

  a_r5_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  a_r7_serial_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fac_q |-> (tx_ser_o == $past(rx_ser_i)));

  a_r8_parallel_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eqp_q && rx_bclk_o) |-> (rx_byte_o == $past(tx_byte_i) && $past(tx_bclk_o)));

  a_r8_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eqp_q |-> !frame_o);

  a_r9_loop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_bclk_o) |-> ($stable(fac_q) && $stable(eqp_q)));
endmodule

bind byte_serdes_framer byte_serdes_framer_chk #(.W(W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_byte_i(tx_byte_i), .tx_bclk_o(tx_bclk_o),
  .tx_ser_o(tx_ser_o), .rx_ser_i(rx_ser_i), .rx_byte_o(rx_byte_o),
  .rx_bclk_o(rx_bclk_o), .frame_o(frame_o), .fac_q(fac_q), .eqp_q(eqp_q)
);

// File: tb/test_byte_serdes_framer.sv
module test_byte_serdes_framer;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic       rx_ser_i = 1'b0, hunt_i = 1'b0;
  logic       serial_loop_i = 1'b0, parallel_loop_i = 1'b0;
  logic       tx_bclk_o, tx_ser_o, rx_bclk_o, frame_o;
  logic [7:0] rx_byte_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  byte_serdes_framer i_byte_serdes_framer (.*);

  localparam logic [7:0] TX_VEC [8] =
    '{8'hA5, 8'h00, 8'hFF, 8'h81, 8'h7E, 8'h01, 8'h80, 8'h3C};
  localparam logic [47:0] SYNC = 48'hF6F6F6_282828;

  logic [7:0] log_b [64];
  bit         log_f [64];
  int         log_n = 0;
  bit         log_en = 0;

  always @(negedge clk_i)
    if (log_en && rx_bclk_o && log_n < 64) begin
      log_b[log_n] = rx_byte_o;
      log_f[log_n] = frame_o;
      log_n++;
    end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_bclk();
    do @(negedge clk_i); while (!tx_bclk_o);
  endtask

  // call at a negedge with tx_bclk_o high; returns at the next such negedge
  task automatic send_byte(logic [7:0] b, logic [7:0] exp, bit chk_eq);
    logic [7:0] got;
    tx_byte_i = b;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk_i);
      got[i] = tx_ser_o;
      if (i == 7 && chk_eq)
        chk(rx_bclk_o && rx_byte_o == b && !frame_o, "R8 parallel loop byte",
            {rx_bclk_o, frame_o, rx_byte_o}, {2'b10, b});
    end
    chk(got == exp, "R2 serial bits", got, exp);
  endtask

  task automatic rx_bits(logic [63:0] v, int n, bit chk_fac);
    for (int i = n - 1; i >= 0; i--) begin
      rx_ser_i = v[i];
      @(negedge clk_i);
      if (chk_fac) chk(tx_ser_o == v[i], "R7 serial loop bit", tx_ser_o, v[i]);
    end
  endtask

  task automatic flush();
    rx_bits(64'h0, 64, 0);
  endtask

  // find the framed byte and check its neighbourhood
  task automatic check_frame(logic [23:0] data, string tag);
    int j = -1, nf = 0;
    for (int k = 0; k < log_n; k++) if (log_f[k]) begin nf++; if (j < 0) j = k; end
    chk(nf == 1, "R5 one frame marker", nf, 1);
    if (j >= 5 && j + 3 < log_n) begin
      chk({log_b[j-5], log_b[j-4], log_b[j-3], log_b[j-2], log_b[j-1], log_b[j]} == SYNC,
          "R4 aligned sync bytes",
          {log_b[j-2], log_b[j-1], log_b[j]}, 24'h282828);
      chk(log_b[j] == 8'h28, "R5 marker on last sync byte", log_b[j], 8'h28);
      chk({log_b[j+1], log_b[j+2], log_b[j+3]} == data, tag,
          {log_b[j+1], log_b[j+2], log_b[j+3]}, data);
    end else chk(0, "R4 frame position", j, 5);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    logic [7:0] got;
    repeat (3) @(negedge clk_i);
    chk(!tx_ser_o && !tx_bclk_o && !rx_bclk_o && !frame_o && rx_byte_o == 0,
        "R3 reset outputs", {tx_ser_o, tx_bclk_o, rx_bclk_o, frame_o, rx_byte_o}, 0);
    rst_ni = 1'b1;

    // R1: first strobe after 7 edges, then every 8
    k = 0;
    do begin @(negedge clk_i); k++; end while (!tx_bclk_o && k < 20);
    chk(k == 7, "R1 first strobe", k, 7);
    k = 0;
    do begin @(negedge clk_i); k++; end while (!tx_bclk_o && k < 20);
    chk(k == 8, "R1 strobe period", k, 8);

    // R2: table walk
    foreach (TX_VEC[i]) send_byte(TX_VEC[i], TX_VEC[i], 0);

    // R9 then R7: serial loop raised mid-byte
    rx_ser_i = 1'b0;
    tx_byte_i = 8'hFF;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk_i);
      if (i == 7) serial_loop_i = 1'b1;
      got[i] = tx_ser_o;
    end
    chk(got == 8'hFF, "R9 mid-byte select ignored", got, 8'hFF);
    send_byte(8'hFF, 8'h00, 0);  // R7 loop active from the boundary
    rx_bits(64'hA53C, 16, 1);
    serial_loop_i = 1'b0;
    wait_bclk(); wait_bclk();

    // R8: parallel loop
    parallel_loop_i = 1'b1;
    wait_bclk();
    send_byte(8'h11, 8'h11, 0);
    send_byte(8'h3C, 8'h3C, 1);
    send_byte(8'hF6, 8'hF6, 1);
    send_byte(8'h00, 8'h00, 1);
    parallel_loop_i = 1'b0;
    wait_bclk(); wait_bclk();

    // R4/R5: alignment from an odd offset
    hunt_i = 1'b1;
    log_n = 0; log_en = 1;
    rx_bits(64'h1A5B, 13, 0);
    rx_bits({16'h0, SYNC}, 48, 0);
    rx_bits(64'h11C35A, 24, 0);
    flush();
    check_frame(24'h11C35A, "R4 data after sync, offset A");

    // R6: hold with shifted sequence
    hunt_i = 1'b0;
    log_n = 0;
    rx_bits(64'h5, 3, 0);
    rx_bits({16'h0, SYNC}, 48, 0);
    rx_bits(64'h11C35A, 24, 0);
    flush();
    k = 0;
    for (int i = 0; i < log_n; i++) if (log_f[i] || log_b[i] == 8'hF6) k++;
    chk(k == 0, "R6 no realign or marker while held", k, 0);
    chk(log_n >= 14, "R6 bytes keep flowing", log_n, 14);

    // R4 again: re-armed at the new offset
    hunt_i = 1'b1;
    log_n = 0;
    rx_bits({16'h0, SYNC}, 48, 0);
    rx_bits(64'h7E8101, 24, 0);
    flush();
    check_frame(24'h7E8101, "R4 data after sync, offset B");
    log_en = 0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule